// File: doc/BRIEF.md
# Framed TDM Serial Byte Receiver

The block recovers parallel bytes from a time-division-multiplexed serial stream that arrives one bit per clock. It keeps a local frame position counter. The low bits of this counter give the bit position within a byte, and the high bits give the timeslot. A frame-alignment strobe from the sender resets the counter to zero, so the local position stays in step with the sender's position.

Incoming bits pass through a serial-in parallel-out shift register. When the last bit of a byte is sampled, the assembled byte and its timeslot number are captured into output registers. A single-cycle valid strobe marks the capture. The output registers keep their values until the next byte completes. Clock recovery and error detection are outside the block.

Top module: `tdm_rx`

## Requirements
- R1: While `rst_ni` is low, `data_o` and `slot_o` are zero, `valid_o` is low, and the receiver is unaligned.
- R2: While unaligned, `valid_o` stays low. The receiver is unaligned after reset and until the first clock edge that samples `sync_i` high.
- R3: A clock edge that samples `sync_i` high sets the position counter to zero. The bit sampled on the next edge is bit position 0 of timeslot 0.
- R4: Bits arrive most significant bit first. The bit at position 0 lands in `data_o[7]` and the bit at position 7 lands in `data_o[0]`.
- R5: `valid_o` goes high for exactly one cycle, immediately after the edge that samples position 7 of an aligned byte.
- R6: `slot_o` gives the timeslot (the counter's upper five bits) of the byte shown on `data_o`.
- R7: `data_o` and `slot_o` keep their values between byte completions.
- R8: The counter wraps modulo 256. After timeslot 31 comes timeslot 0 with no new sync.
- R9: A sync in the middle of a byte discards the partial byte. A sync sampled on the same edge as position 7 produces no byte, and the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data, one bit per clock |
| sync_i | input | 1 | Frame-alignment strobe; zeroes the counter |
| data_o | output | 8 | Last recovered byte |
| slot_o | output | 5 | Timeslot of `data_o` |
| valid_o | output | 1 | One-cycle byte-complete strobe |

## Verification
The bench builds the block with its default widths: five slot bits and three bit-position bits. This gives 32 timeslots of 8 bits, so a full 256-bit frame fits in the run. The wrap from slot 31 back to slot 0 without a sync can therefore be observed directly. These widths also let the bench probe each edge that matters: the position-7 edge, a sync in the middle of a byte, and a sync that coincides with position 7.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned DEF_SLOT_W = 5;
  localparam int unsigned DEF_POS_W  = 3;
endpackage

// File: rtl/tdm_rx_cnt.sv
module tdm_rx_cnt #(
  parameter int unsigned SLOT_W = tdm_rx_pkg::DEF_SLOT_W,
  parameter int unsigned POS_W  = tdm_rx_pkg::DEF_POS_W,
  localparam int unsigned CNT_W = SLOT_W + POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              pos_last_o,
  output logic              aligned_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             aligned_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      aligned_q <= 1'b0;
    end else if (sync_i) begin
      cnt_q     <= '0;
      aligned_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  assign slot_o     = cnt_q[CNT_W-1:POS_W];
  assign pos_last_o = &cnt_q[POS_W-1:0];
  assign aligned_o  = aligned_q;

  a_r3_sync_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cnt_q == '0) && aligned_q);
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&cnt_q) && !sync_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tdm_rx_sipo.sv
module tdm_rx_sipo #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-2:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else         shreg_q <= {shreg_q[BYTE_W-3:0], sdata_i};
  end

  // msb-first: the bit arriving now is the lsb of the byte
  assign byte_o = {shreg_q, sdata_i};
endmodule

// File: rtl/tdm_rx_out.sv
module tdm_rx_out #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aligned_i,
  input  logic              pos_last_i,
  input  logic              sync_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  logic              load;
  logic [BYTE_W-1:0] data_q;
  logic [SLOT_W-1:0] slot_q;
  logic              valid_q;

  // sync has priority over completion at position 7
  assign load = aligned_i & pos_last_i & ~sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        data_q <= byte_i;
        slot_q <= slot_i;
      end
    end
  end

  assign data_o  = data_q;
  assign slot_o  = slot_q;
  assign valid_o = valid_q;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> ($stable(data_q) && $stable(slot_q)));
  a_r9_sync_no_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !valid_q);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int unsigned SLOT_W = tdm_rx_pkg::DEF_SLOT_W,
  parameter int unsigned POS_W  = tdm_rx_pkg::DEF_POS_W,
  localparam int unsigned BYTE_W = 1 << POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sync_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  logic [SLOT_W-1:0] cur_slot;
  logic              pos_last;
  logic              aligned;
  logic [BYTE_W-1:0] asm_byte;

  tdm_rx_cnt #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_cnt (
    .clk_i, .rst_ni, .sync_i,
    .slot_o(cur_slot), .pos_last_o(pos_last), .aligned_o(aligned)
  );

  tdm_rx_sipo #(.BYTE_W(BYTE_W)) u_sipo (
    .clk_i, .rst_ni, .sdata_i, .byte_o(asm_byte)
  );

  tdm_rx_out #(.BYTE_W(BYTE_W), .SLOT_W(SLOT_W)) u_out (
    .clk_i, .rst_ni,
    .aligned_i(aligned), .pos_last_i(pos_last), .sync_i,
    .byte_i(asm_byte), .slot_i(cur_slot),
    .data_o, .slot_o, .valid_o
  );

  a_r2_quiet_unaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned |=> !valid_o);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0 && slot_o == '0));
endmodule

// File: tb/sim_tdm_rx.sv
`timescale 1ns/1ps
module sim_tdm_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic sync = 1'b0;
  logic [7:0] data;
  logic [4:0] slot;
  logic       valid;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tdm_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sync_i(sync),
    .data_o(data), .slot_o(slot), .valid_o(valid)
  );

  // {expected slot, byte sent}
  localparam logic [12:0] VEC [8] = '{
    {5'd0, 8'hA5}, {5'd1, 8'h3C}, {5'd2, 8'h80}, {5'd3, 8'h01},
    {5'd4, 8'hFF}, {5'd5, 8'h00}, {5'd6, 8'h96}, {5'd7, 8'h7E}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic s);
    @(negedge clk);
    sdata = b;
    sync  = s;
    @(posedge clk);
    #1;
  endtask

  // sends one byte msb first; optionally checks hold on the first 7 bits
  task automatic send_byte(logic [7:0] b, bit hold_chk);
    logic [7:0] d0 = data;
    logic [4:0] s0 = slot;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], 1'b0);
      if (hold_chk && i > 0) begin
        check("R7 data hold", data, d0);
        check("R7 slot hold", slot, s0);
        check("R5 no valid mid-byte", valid, 0);
      end
    end
  endtask

  task automatic expect_byte(string req, logic [7:0] b, logic [4:0] s);
    check({req, " valid"}, valid, 1);
    check({req, " data"}, data, b);
    check({req, " slot"}, slot, s);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #5;
    check("R1 reset data", data, 0);
    check("R1 reset slot", slot, 0);
    check("R1 reset valid", valid, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: no valid before first sync
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hFF, 1'b0);
      check("R2 unaligned quiet", valid, 0);
    end

    // R3 align, then table walk (R4 msb-first, R5, R6)
    send_bit(1'b1, 1'b1);
    check("R3 sync no byte", valid, 0);
    for (int k = 0; k < 8; k++) begin
      send_byte(VEC[k][7:0], k > 0);
      expect_byte("R4 R6 table", VEC[k][7:0], VEC[k][12:8]);
      if (k == 0) begin
        send_bit(VEC[1][7], 1'b0);
        check("R5 single pulse", valid, 0);
        for (int i = 6; i >= 0; i--) send_bit(VEC[1][i], 1'b0);
        expect_byte("R5 next", VEC[1][7:0], 5'd1);
        k = 1;
      end
    end

    // R8: rest of the frame and wrap to slot 0 without sync
    for (int s = 8; s < 32; s++) begin
      send_byte(8'(s * 37 + 11), 1'b0);
      expect_byte("R6 slot", 8'(s * 37 + 11), 5'(s));
    end
    send_byte(8'h5A, 1'b1);
    expect_byte("R8 wrap", 8'h5A, 5'd0);

    // R9: sync mid-byte discards partial
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1);
    check("R9 mid sync no byte", valid, 0);
    send_byte(8'hC3, 1'b0);
    expect_byte("R9 realign", 8'hC3, 5'd0);

    // R9: sync on position-7 edge yields no byte
    for (int i = 7; i >= 1; i--) send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    check("R9 sync at pos7 valid", valid, 0);
    check("R9 sync at pos7 data", data, 8'hC3);
    send_byte(8'h69, 1'b1);
    expect_byte("R9 after pos7 sync", 8'h69, 5'd0);

    // R1/R2: reset mid-stream, then no bytes without sync
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 async data", data, 0);
    check("R1 async valid", valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      send_byte(8'hAA, 1'b0);
      check("R2 after reset quiet", valid, 0);
    end
    finish_run();
  end
endmodule